// File: doc/BRIEF.md
# HDLC Status Event Collector with Interrupt Masking

This unit gathers status strobes from an HDLC serial channel into a sticky 16-bit event register and pairs it with a 16-bit mask register that uses the same bit layout. When any event bit is set and its matching mask bit is one, a single registered interrupt request goes high. Software reads either register through a small read/write port and acknowledges an event by writing a one to its bit.

Most events are taken directly from single-cycle strobes. Three events need timing qualification first. Frame-received is delayed two clocks after the closing-flag strobe. Buffer-transmitted is either immediate or held until the closing flag starts, depending on whether the buffer ends a frame. Graceful-stop-complete is raised at once, or only after the frame in flight finishes. Two small state machines and a delay line handle these rules.

The graceful-stop machine has three states. `GS_IDLE` goes to `GS_DONE` on a command when no frame is active, and to `GS_WAIT` on a command during a frame. `GS_WAIT` goes to `GS_DONE` on the frame-end strobe. `GS_DONE` returns to `GS_IDLE` after one cycle, and the event strobe is asserted while the machine is in `GS_DONE`. The buffer-transmitted machine has two states. `TB_IDLE` goes to `TB_HOLD` when a frame-ending buffer has had its last byte written. `TB_HOLD` goes back to `TB_IDLE` on the closing-flag-start strobe, and raises the event on that transition.

Top module: `hdlc_evt_unit`

## Requirements
- R1: Event bit positions are: 0 buffer received, 1 buffer transmitted, 2 busy, 3 frame received, 4 transmit error, 5 graceful stop complete, 6 idle changed, 7 flag changed, 8 carrier-sense changed, 9 transmit glitch. Bits 15..10 always read as zero.
- R2: After reset the event register and the mask register read zero and `irq` is low. The mask register stores and reads back all 16 written bits.
- R3: A strobe on the glitch, carrier-sense, flag, idle, discard or partial-buffer input sets its event bit at that clock edge, and the bit stays set until it is cleared.
- R4: A CTS-lost strobe and an underrun strobe each set the transmit-error bit (bit 4).
- R5: Writing to the event register (`reg_sel`=0) clears each bit written as one and leaves bits written as zero unchanged. A set in the same cycle as a clear leaves the bit set.
- R6: `irq` is registered: one cycle after (event AND mask) becomes non-zero it goes high, and one cycle after that AND becomes zero it goes low. An event whose mask bit is zero never raises `irq`.
- R7: A closing-flag-received strobe sampled at edge k sets frame-received at edge k+2 and not earlier.
- R8: A buffer-done strobe with `tx_buf_last`=0 sets buffer-transmitted at the same edge.
- R9: A buffer-done strobe with `tx_buf_last`=1 defers buffer-transmitted until the next closing-flag-start strobe, which sets it at that edge. A closing-flag-start strobe with nothing deferred has no effect.
- R10: A graceful-stop command sampled at edge k while `tx_frame_busy`=0 sets graceful-stop-complete at edge k+1.
- R11: A graceful-stop command during a frame sets graceful-stop-complete one edge after the frame-end strobe. Further commands while waiting add no event, and a frame-end strobe with no stop pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_glitch_p | input | 1 | Transmit-clock glitch strobe |
| cs_change_p | input | 1 | Recovered carrier-sense change strobe |
| flag_change_p | input | 1 | Flag reception started/stopped strobe |
| idle_change_p | input | 1 | Line idle status change strobe |
| cts_lost_p | input | 1 | CTS lost during transmission strobe |
| tx_underrun_p | input | 1 | Transmitter underrun strobe |
| rx_discard_p | input | 1 | Received frame dropped for lack of buffers |
| rx_part_buf_p | input | 1 | Receive buffer closed without a complete frame |
| rx_close_done_p | input | 1 | Last bit of the closing flag received |
| tx_buf_done_p | input | 1 | Last byte of a transmit buffer written to the FIFO |
| tx_buf_last | input | 1 | Qualifies `tx_buf_done_p`: buffer ends a frame |
| tx_close_start_p | input | 1 | Last bit of the closing flag starts transmitting |
| gstop_cmd_p | input | 1 | Graceful-stop command strobe |
| tx_frame_busy | input | 1 | A transmit frame is in progress |
| tx_frame_end_p | input | 1 | The transmit frame in progress has finished |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 1 | 0 selects the event register, 1 selects the mask register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request, registered |

## Verification
Direct strobes and a non-final buffer-done land in the event register at the edge that samples them. Graceful-stop completion lands one edge later, and frame-received lands two edges later. `irq` follows the register state by one more edge. The bench drives every input just after a falling edge and reads `reg_rdata` and `irq` before the next falling edge, so each sample counts exactly the registers between stimulus and result. For the delayed events it also checks the intermediate cycles, to show the bit is not set early. Deferred and waiting cases hold the strobe back for several idle cycles and confirm the bit stays clear until the releasing strobe.

// File: rtl/hdlc_evt_pkg.sv
package hdlc_evt_pkg;

    localparam int EVW     = 16;
    localparam int B_RXB   = 0;
    localparam int B_TXB   = 1;
    localparam int B_BSY   = 2;
    localparam int B_RXF   = 3;
    localparam int B_TXE   = 4;
    localparam int B_GST   = 5;
    localparam int B_IDL   = 6;
    localparam int B_FLG   = 7;
    localparam int B_CSC   = 8;
    localparam int B_GLT   = 9;
    localparam int NUM_EV  = 10;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_WAIT = 2'd1,
        GS_DONE = 2'd2
    } gs_state_e;

    typedef enum logic {
        TB_IDLE = 1'b0,
        TB_HOLD = 1'b1
    } tb_state_e;

endpackage

// File: rtl/hdlc_rx_delay.sv
module hdlc_rx_delay #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_p,
    output logic out_p
);

    logic [DLY-1:0] stage_q;

    generate
        if (DLY == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= in_p;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[DLY-2:0], in_p};
            end
        end
    endgenerate

    assign out_p = stage_q[DLY-1];

endmodule

// File: rtl/hdlc_gstop_fsm.sv
module hdlc_gstop_fsm
    import hdlc_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_p,
    input  logic frame_busy,
    input  logic frame_end_p,
    output logic done_p,
    output logic busy
);

    gs_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: if (cmd_p) state_d = frame_busy ? GS_WAIT : GS_DONE;
            GS_WAIT: if (frame_end_p) state_d = GS_DONE;
            GS_DONE: state_d = GS_IDLE;
            default: state_d = GS_IDLE;
        endcase
    end

    always_comb begin
        done_p = (state_q == GS_DONE);
        busy   = (state_q != GS_IDLE);
    end

endmodule

// File: rtl/hdlc_txb_qual.sv
module hdlc_txb_qual
    import hdlc_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic buf_done_p,
    input  logic buf_last,
    input  logic close_start_p,
    output logic set_p
);

    tb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_IDLE: if (buf_done_p && buf_last) state_d = TB_HOLD;
            TB_HOLD: if (close_start_p && !(buf_done_p && buf_last)) state_d = TB_IDLE;
            default: state_d = TB_IDLE;
        endcase
    end

    always_comb begin
        set_p = (buf_done_p && !buf_last) || ((state_q == TB_HOLD) && close_start_p);
    end

endmodule

// File: rtl/hdlc_evt_unit.sv
module hdlc_evt_unit
    import hdlc_evt_pkg::*;
#(
    parameter int               W        = EVW,
    parameter int               RXF_DLY  = 2,
    parameter logic [EVW-1:0]   IMPL_MSK = 16'h03FF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_glitch_p,
    input  logic         cs_change_p,
    input  logic         flag_change_p,
    input  logic         idle_change_p,
    input  logic         cts_lost_p,
    input  logic         tx_underrun_p,
    input  logic         rx_discard_p,
    input  logic         rx_part_buf_p,
    input  logic         rx_close_done_p,
    input  logic         tx_buf_done_p,
    input  logic         tx_buf_last,
    input  logic         tx_close_start_p,
    input  logic         gstop_cmd_p,
    input  logic         tx_frame_busy,
    input  logic         tx_frame_end_p,
    input  logic         reg_wr,
    input  logic         reg_sel,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         irq
);

    logic [W-1:0] ev_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;
    logic         rxf_set;
    logic         txb_set;
    logic         gs_done;
    logic         gs_busy;

    hdlc_rx_delay #(.DLY(RXF_DLY)) rxf_dly_i (
        .clk   (clk),
        .rst_n (rst_n),
        .in_p  (rx_close_done_p),
        .out_p (rxf_set)
    );

    hdlc_txb_qual txb_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .buf_done_p    (tx_buf_done_p),
        .buf_last      (tx_buf_last),
        .close_start_p (tx_close_start_p),
        .set_p         (txb_set)
    );

    hdlc_gstop_fsm gstop_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_p       (gstop_cmd_p),
        .frame_busy  (tx_frame_busy),
        .frame_end_p (tx_frame_end_p),
        .done_p      (gs_done),
        .busy        (gs_busy)
    );

    always_comb begin
        set_vec        = '0;
        set_vec[B_RXB] = rx_part_buf_p;
        set_vec[B_TXB] = txb_set;
        set_vec[B_BSY] = rx_discard_p;
        set_vec[B_RXF] = rxf_set;
        set_vec[B_TXE] = cts_lost_p | tx_underrun_p;
        set_vec[B_GST] = gs_done;
        set_vec[B_IDL] = idle_change_p;
        set_vec[B_FLG] = flag_change_p;
        set_vec[B_CSC] = cs_change_p;
        set_vec[B_GLT] = tx_glitch_p;
        clr_vec        = (reg_wr && !reg_sel) ? reg_wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q   <= '0;
            mask_q <= '0;
            irq    <= 1'b0;
        end else begin
            ev_q <= ((ev_q & ~clr_vec) | set_vec) & IMPL_MSK[W-1:0];
            if (reg_wr && reg_sel) mask_q <= reg_wdata;
            irq  <= |(ev_q & mask_q);
        end
    end

    always_comb begin
        reg_rdata = reg_sel ? mask_q : ev_q;
    end

endmodule

// File: rtl/hdlc_evt_unit_chk.sv
module hdlc_evt_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] ev_q,
    input logic [15:0] mask_q,
    input logic [15:0] set_vec,
    input logic        irq,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [15:0] reg_wdata,
    input logic        gstop_cmd_p,
    input logic        tx_frame_busy,
    input logic        gs_busy,
    input logic        gs_done,
    input logic        txb_set,
    input logic        tx_buf_done_p,
    input logic        tx_buf_last,
    input logic        tx_close_start_p
);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q[15:10] == 6'd0);

    // R3
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((ev_q & $past(set_vec)) == $past(set_vec)));

    // R5
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |=> ((ev_q & $past(reg_wdata) & ~$past(set_vec)) == 16'h0));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_q & mask_q)) |=> irq);

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(ev_q & mask_q)) |=> !irq);

    // R10
    gstop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gstop_cmd_p && !tx_frame_busy && !gs_busy) |=> gs_done);

    // R9
    txb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txb_set |-> ((tx_buf_done_p && !tx_buf_last) || tx_close_start_p));

endmodule

bind hdlc_evt_unit hdlc_evt_unit_chk chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .ev_q             (ev_q),
    .mask_q           (mask_q),
    .set_vec          (set_vec),
    .irq              (irq),
    .reg_wr           (reg_wr),
    .reg_sel          (reg_sel),
    .reg_wdata        (reg_wdata),
    .gstop_cmd_p      (gstop_cmd_p),
    .tx_frame_busy    (tx_frame_busy),
    .gs_busy          (gs_busy),
    .gs_done          (gs_done),
    .txb_set          (txb_set),
    .tx_buf_done_p    (tx_buf_done_p),
    .tx_buf_last      (tx_buf_last),
    .tx_close_start_p (tx_close_start_p)
);

// File: tb/hdlc_evt_unit_tb_top.sv
module hdlc_evt_unit_tb_top;

    localparam int P_GLT = 0, P_CSC = 1, P_FLG = 2, P_IDL = 3, P_CTS = 4, P_UND = 5,
                   P_DSC = 6, P_PRT = 7, P_RXC = 8, P_BDN = 9, P_BLS = 10, P_CLS = 11,
                   P_GCM = 12, P_FEN = 13;

    // {input strobes[7:0], mask[15:0], expected event[15:0], expected irq}
    localparam int NV = 10;
    localparam logic [40:0] VEC [NV] = '{
        {8'h01, 16'h0200, 16'h0200, 1'b1},
        {8'h02, 16'h0000, 16'h0100, 1'b0},
        {8'h04, 16'hFFFF, 16'h0080, 1'b1},
        {8'h08, 16'h0080, 16'h0040, 1'b0},
        {8'h10, 16'h0010, 16'h0010, 1'b1},
        {8'h20, 16'h0000, 16'h0010, 1'b0},
        {8'h40, 16'h0004, 16'h0004, 1'b1},
        {8'h80, 16'h0001, 16'h0001, 1'b1},
        {8'hFF, 16'h0300, 16'h03D5, 1'b1},
        {8'h00, 16'hFFFF, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] drv = '0;
    logic        frame_busy = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] rv;

    always #5 clk = ~clk;

    hdlc_evt_unit dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .tx_glitch_p      (drv[P_GLT]),
        .cs_change_p      (drv[P_CSC]),
        .flag_change_p    (drv[P_FLG]),
        .idle_change_p    (drv[P_IDL]),
        .cts_lost_p       (drv[P_CTS]),
        .tx_underrun_p    (drv[P_UND]),
        .rx_discard_p     (drv[P_DSC]),
        .rx_part_buf_p    (drv[P_PRT]),
        .rx_close_done_p  (drv[P_RXC]),
        .tx_buf_done_p    (drv[P_BDN]),
        .tx_buf_last      (drv[P_BLS]),
        .tx_close_start_p (drv[P_CLS]),
        .gstop_cmd_p      (drv[P_GCM]),
        .tx_frame_busy    (frame_busy),
        .tx_frame_end_p   (drv[P_FEN]),
        .reg_wr           (reg_wr),
        .reg_sel          (reg_sel),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .irq              (irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [13:0] v);
        drv = v;
        @(negedge clk);
        drv = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(1'b0, rv); check("R2 event after reset", rv, 16'h0000);
        rd(1'b1, rv); check("R2 mask after reset", rv, 16'h0000);
        check("R2 irq after reset", {15'd0, irq}, 16'h0000);

        // vector table: R3 R4 R6 R1
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, 16'hFFFF);
            wr(1'b1, VEC[i][32:17]);
            rd(1'b1, rv); check("R2 mask readback", rv, VEC[i][32:17]);
            drv[7:0] = VEC[i][40:33];
            @(negedge clk);
            drv = '0;
            rd(1'b0, rv); check("R3/R4/R1 event vector", rv, VEC[i][16:1]);
            @(negedge clk);
            check("R6 irq vector", {15'd0, irq}, {15'd0, VEC[i][0]});
        end

        // R1 reserved bits with full mask and all events
        wr(1'b1, 16'hFFFF);
        pulse(14'h00FF);
        rd(1'b0, rv); check("R1 reserved bits zero", {10'd0, rv[15:10]}, 16'h0000);

        // R6 irq falls one cycle after clear
        @(negedge clk);
        check("R6 irq set", {15'd0, irq}, 16'h0001);
        wr(1'b0, 16'hFFFF);
        check("R6 irq still high one cycle", {15'd0, irq}, 16'h0001);
        @(negedge clk);
        check("R6 irq dropped", {15'd0, irq}, 16'h0000);

        // R5 write zero keeps, write one clears, set beats clear
        pulse(14'h0001 << P_GLT);
        wr(1'b0, 16'h0000);
        rd(1'b0, rv); check("R5 write zero keeps", rv, 16'h0200);
        wr(1'b0, 16'h0200);
        rd(1'b0, rv); check("R5 write one clears", rv, 16'h0000);
        drv[P_GLT] = 1'b1;
        wr(1'b0, 16'h0200);
        drv = '0;
        rd(1'b0, rv); check("R5 set wins over clear", rv, 16'h0200);
        wr(1'b0, 16'hFFFF);

        // R7 frame received delay
        pulse(14'h0001 << P_RXC);
        rd(1'b0, rv); check("R7 not at k", rv, 16'h0000);
        @(negedge clk);
        rd(1'b0, rv); check("R7 not at k+1", rv, 16'h0000);
        @(negedge clk);
        rd(1'b0, rv); check("R7 set at k+2", rv, 16'h0008);
        wr(1'b0, 16'hFFFF);

        // R8 non-final buffer
        pulse(14'h0001 << P_BDN);
        rd(1'b0, rv); check("R8 immediate buffer tx", rv, 16'h0002);
        wr(1'b0, 16'hFFFF);

        // R9 final buffer deferred
        pulse(14'h0001 << P_CLS);
        rd(1'b0, rv); check("R9 stray flag start ignored", rv, 16'h0000);
        pulse((14'h0001 << P_BDN) | (14'h0001 << P_BLS));
        idle(3);
        rd(1'b0, rv); check("R9 deferred until flag", rv, 16'h0000);
        pulse(14'h0001 << P_CLS);
        rd(1'b0, rv); check("R9 set at flag start", rv, 16'h0002);
        wr(1'b0, 16'hFFFF);

        // R10 immediate graceful stop
        frame_busy = 1'b0;
        pulse(14'h0001 << P_GCM);
        rd(1'b0, rv); check("R10 not at k", rv, 16'h0000);
        @(negedge clk);
        rd(1'b0, rv); check("R10 set at k+1", rv, 16'h0020);
        wr(1'b0, 16'hFFFF);

        // R11 graceful stop waits for frame end
        pulse(14'h0001 << P_FEN);
        idle(2);
        rd(1'b0, rv); check("R11 stray frame end ignored", rv, 16'h0000);
        frame_busy = 1'b1;
        pulse(14'h0001 << P_GCM);
        idle(3);
        rd(1'b0, rv); check("R11 waits during frame", rv, 16'h0000);
        pulse(14'h0001 << P_GCM);
        idle(2);
        pulse(14'h0001 << P_FEN);
        frame_busy = 1'b0;
        rd(1'b0, rv); check("R11 not at frame-end edge", rv, 16'h0000);
        @(negedge clk);
        rd(1'b0, rv); check("R11 set after frame end", rv, 16'h0020);
        wr(1'b0, 16'hFFFF);
        idle(4);
        rd(1'b0, rv); check("R11 no repeat event", rv, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule